// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This block adds or subtracts two signed-magnitude words. In each word the top bit is the sign (0 positive, 1 negative) and the remaining bits hold the magnitude. One unsigned magnitude adder does the work. The B magnitude passes through a selective complementer on its way in, and the raw result passes through a second selective complementer on its way out. The control logic works out the effective magnitude operation from the two operand signs and the subtract request. In a subtraction, the adder carry-out shows which operand had the larger magnitude. That carry decides whether the raw result is complemented and whether the result sign is flipped.

An overflow flag is raised when a magnitude sum does not fit. A zero result is always produced as positive zero. The result can be taken straight from the logic or through one output register, chosen by a parameter. The output register has an asynchronous active-low reset that is released synchronously inside the block.

Top module: `sm_addsub`

## Requirements
- R1: The effective operation is sign(a) XOR sign(b) XOR sub, where sub=1 requests a-b. When it is 0 the magnitudes are added and the result takes the sign of a. The sign is bit W-1 and the magnitude is bits W-2:0.
- R2: On an effective addition, a carry out of the magnitude field sets ovf=1. The result magnitude is then the low W-1 bits of the sum.
- R3: On an effective subtraction with |a| >= |b|, the result magnitude is |a|-|b| and the result sign is the sign of a.
- R4: On an effective subtraction with |a| < |b|, the result magnitude is |b|-|a| and the result sign is the inverse of the sign of a.
- R5: Any result whose magnitude is zero has sign bit 0. This includes an overflowed sum whose low bits are zero.
- R6: An operand with sign 1 and magnitude 0 gives the same result as positive zero in every operation.
- R7: ovf is 0 on every effective subtraction.
- R8: With REG_OUT=1, res and ovf change one clock edge after the inputs are applied, and they hold between edges. While rst_n is low, res and ovf are 0, and asserting rst_n clears them without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | W | Operand A: bit W-1 sign, low bits magnitude |
| b | input | W | Operand B: same layout as A |
| sub | input | 1 | 1 requests a-b, 0 requests a+b |
| res | output | W | Signed-magnitude result |
| ovf | output | 1 | Magnitude overflow on effective addition |

## Verification
The immediate checks inside the magnitude core assume the operands and the operation select carry known values. They stay silent on any cycle where one of these is still unknown. The bench drives every input to a defined value before the first clock edge, so that condition is never reached. The clocked hold check assumes the register has been out of reset for a full cycle before it compares outputs. The bench therefore waits several cycles after reset release before it starts the vector table, and it changes inputs only on falling edges.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } sm_op_e;
endpackage

// File: rtl/sm_op_decode.sv
module sm_op_decode
  import sm_pkg::*;
(
  input  logic   sign_a,
  input  logic   sign_b,
  input  logic   sub,
  output sm_op_e op
);
  // Effective magnitude operation (R1)
  always_comb begin
    op = (sign_a ^ sign_b ^ sub) ? OP_SUB : OP_ADD;
  end
endmodule

// File: rtl/sm_mag_core.sv
module sm_mag_core
  import sm_pkg::*;
#(
  parameter int MW = 7
) (
  input  logic [MW-1:0] mag_a,
  input  logic [MW-1:0] mag_b,
  input  sm_op_e        op,
  output logic [MW-1:0] mag_o,
  output logic          flip,
  output logic          ovf
);
  localparam int AW = MW + 1;

  logic [MW-1:0] b_sel;
  logic          cin;
  logic [AW-1:0] raw;
  logic          carry;

  // Input-side selective complement, carry-in supplies the ulp
  always_comb begin
    b_sel = (op == OP_SUB) ? ~mag_b : mag_b;
    cin   = (op == OP_SUB);
  end

  // The single magnitude adder
  always_comb begin
    raw   = {1'b0, mag_a} + {1'b0, b_sel} + AW'(cin);
    carry = raw[MW];
  end

  // Output-side selective complement (exact: invert plus ulp)
  always_comb begin
    flip  = (op == OP_SUB) && !carry;
    ovf   = (op == OP_ADD) && carry;
    mag_o = flip ? (~raw[MW-1:0] + MW'(1)) : raw[MW-1:0];
  end

  // Checks against an independent arithmetic model
  logic [MW-1:0] hi_m, lo_m;
  always_comb begin
    hi_m = (mag_a >= mag_b) ? mag_a : mag_b;
    lo_m = (mag_a >= mag_b) ? mag_b : mag_a;
  end

  always_comb begin
    if (!$isunknown({mag_a, mag_b, op})) begin
      if (op == OP_ADD) begin
        p_add_exact_r2 : assert ({ovf, mag_o} == ({1'b0, mag_a} + {1'b0, mag_b}))
          else $error("R2 magnitude sum mismatch");
      end else begin
        p_sub_exact_r3 : assert (MW'(mag_o + lo_m) == hi_m)
          else $error("R3 magnitude difference mismatch");
        p_flip_r4 : assert (flip == (mag_a < mag_b))
          else $error("R4 complement decision mismatch");
        p_no_overflow_r7 : assert (!ovf)
          else $error("R7 overflow on subtraction");
      end
    end
  end
endmodule

// File: rtl/sm_out_stage.sv
module sm_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         sign_raw,
  input  logic [W-2:0] mag,
  input  logic         ovf_in,
  output logic [W-1:0] res,
  output logic         ovf
);
  logic [W-1:0] res_nxt;
  logic         ovf_nxt;

  // Canonical zero: a zero magnitude always leaves with sign 0 (R5)
  always_comb begin
    res_nxt = {sign_raw & (|mag), mag};
    ovf_nxt = ovf_in;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] res_q;
      logic         ovf_q;
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) begin
          res_q <= '0;
          ovf_q <= 1'b0;
        end else begin
          res_q <= res_nxt;
          ovf_q <= ovf_nxt;
        end
      end
      assign res = res_q;
      assign ovf = ovf_q;
    end else begin : g_comb
      assign res = res_nxt;
      assign ovf = ovf_nxt;
    end
  endgenerate
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import sm_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int MW = W - 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  sm_op_e        op;
  logic [MW-1:0] mag;
  logic          flip;
  logic          ovf_c;
  logic          sign_raw;

  sm_op_decode u_dec (
    .sign_a (a[W-1]),
    .sign_b (b[W-1]),
    .sub    (sub),
    .op     (op)
  );

  sm_mag_core #(.MW(MW)) u_core (
    .mag_a (a[MW-1:0]),
    .mag_b (b[MW-1:0]),
    .op    (op),
    .mag_o (mag),
    .flip  (flip),
    .ovf   (ovf_c)
  );

  // Result sign follows a, inverted when the difference was recomplemented
  always_comb sign_raw = a[W-1] ^ flip;

  sm_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_sn   (rst_s),
    .sign_raw (sign_raw),
    .mag      (mag),
    .ovf_in   (ovf_c),
    .res      (res),
    .ovf      (ovf)
  );

  p_zero_pos_r5 : assert property (@(posedge clk) disable iff (!rst_s)
    (res[W-2:0] == '0) |-> !res[W-1])
    else $error("R5 negative zero emitted");

  generate
    if (REG_OUT) begin : g_chk
      p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_s)
        ($past(rst_s) && a == $past(a) && b == $past(b) && sub == $past(sub))
        |=> $stable({res, ovf}))
        else $error("R8 output moved with steady inputs");
    end
  endgenerate
endmodule

// File: tb/sim_sm_addsub.sv
module sim_sm_addsub;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a, b;
  logic         sub;
  logic [W-1:0] res;
  logic         ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sm_addsub #(.W(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sub(sub), .res(res), .ovf(ovf)
  );

  // {a, b, sub, expected res, expected ovf}
  localparam int NV = 17;
  localparam logic [25:0] VEC [NV] = '{
    {8'h0B, 8'h06, 1'b0, 8'h11, 1'b0},  // R1 +11 + +6
    {8'h85, 8'h83, 1'b0, 8'h88, 1'b0},  // R1 -5 + -3
    {8'h8B, 8'h06, 1'b0, 8'h85, 1'b0},  // R3 -11 + +6
    {8'h7F, 8'h81, 1'b0, 8'h7E, 1'b0},  // R3 +127 + -1
    {8'h06, 8'h8B, 1'b0, 8'h85, 1'b0},  // R4 +6 + -11
    {8'h06, 8'h0B, 1'b1, 8'h85, 1'b0},  // R4 +6 - +11
    {8'h9E, 8'hB2, 1'b1, 8'h14, 1'b0},  // R4 -30 - -50
    {8'h01, 8'h7F, 1'b1, 8'hFE, 1'b0},  // R4 +1 - +127
    {8'h64, 8'h32, 1'b0, 8'h16, 1'b1},  // R2 +100 + +50
    {8'hE4, 8'h32, 1'b1, 8'h96, 1'b1},  // R2 -100 - +50
    {8'h7F, 8'hFF, 1'b1, 8'h7E, 1'b1},  // R2 +127 - -127
    {8'hC0, 8'hC0, 1'b0, 8'h00, 1'b1},  // R5 -64 + -64 wraps to zero
    {8'h14, 8'h14, 1'b1, 8'h00, 1'b0},  // R5 +20 - +20
    {8'h94, 8'h14, 1'b0, 8'h00, 1'b0},  // R5 -20 + +20
    {8'h80, 8'h05, 1'b0, 8'h05, 1'b0},  // R6 -0 + +5
    {8'h05, 8'h80, 1'b0, 8'h05, 1'b0},  // R6 +5 + -0
    {8'h80, 8'h80, 1'b1, 8'h00, 1'b0}   // R6 -0 - -0
  };

  task automatic chk(input string req, input logic [W-1:0] got_r, input logic [W-1:0] exp_r,
                     input logic got_o, input logic exp_o);
    n_chk++;
    if (got_r !== exp_r || got_o !== exp_o) begin
      n_bad++;
      $display("FAIL %s: res=%h ovf=%b expected res=%h ovf=%b", req, got_r, got_o, exp_r, exp_o);
    end
  endtask

  initial begin
    rst_n = 1'b0; a = '0; b = '0; sub = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset", res, 8'h00, ovf, 1'b0);
    a = 8'h0B; b = 8'h06;
    @(negedge clk);
    chk("R8 reset held", res, 8'h00, ovf, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      a   = VEC[i][25:18];
      b   = VEC[i][17:10];
      sub = VEC[i][9];
      @(negedge clk);
      chk($sformatf("R1-table vector %0d (R2 R3 R4 R5 R6 R7)", i),
          res, VEC[i][8:1], ovf, VEC[i][0]);
    end

    // R8: one-edge latency, output holds before the edge
    a = 8'h0B; b = 8'h06; sub = 1'b0;
    @(negedge clk);
    chk("R8 settle", res, 8'h11, ovf, 1'b0);
    a = 8'h8B; b = 8'h06; sub = 1'b0;
    #2;
    chk("R8 hold before edge", res, 8'h11, ovf, 1'b0);
    @(negedge clk);
    chk("R8 after edge", res, 8'h85, ovf, 1'b0);

    // R7: subtraction of extreme magnitudes never flags overflow
    a = 8'hFF; b = 8'h7F; sub = 1'b0;
    @(negedge clk);
    chk("R7 -127 + +127", res, 8'h00, ovf, 1'b0);

    // R8: asynchronous clear mid-run
    a = 8'h64; b = 8'h32; sub = 1'b0;
    @(negedge clk);
    chk("R8 before clear", res, 8'h16, ovf, 1'b1);
    #2 rst_n = 1'b0;
    #1;
    chk("R8 async clear", res, 8'h00, ovf, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 after re-release", res, 8'h16, ovf, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule